// File: doc/BRIEF.md
# Translation Fault Collector and Interrupt Gate

This block sits beside an address-translation unit and gathers the fault events raised by the lookup and table-walk logic. Each of five event sources owns a sticky status bit. Software acknowledges a bit by writing 1 to it. A per-source enable mask selects which pending bits drive the single registered interrupt line.

The first fault seen while no fault is outstanding freezes a record of the request that caused it. The record holds the virtual address, the requesting master, the request kind and the direction. It stays unchanged until software clears the outstanding-fault flag. A second register always follows the address of the most recent debug-time miss, whether or not a record is frozen.

Software reaches everything through a small word-addressed port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the address is presented.

Top module: `xlat_fault_unit`

## Requirements
- R1: After a synchronous reset, the status, enable, fault record, debug address, interrupt and read data are all zero.
- R2: A pulse on event line i sets status bit i, read at word 0, at the next clock edge. Bit 0 is multi-hit, bit 1 is walk error response, bit 2 is debug-time miss, bit 3 is invalid descriptor and bit 4 is miss with walking disabled. A status bit never rises without its event.
- R3: Writing word 0 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: The output `irq` equals the OR over all bits of (status AND enable), delayed by one register. An event whose enable bit is 0 sets its status but leaves `irq` low.
- R5: When no fault is outstanding, any event captures the fault record. Word 2 holds the virtual address. Word 3 holds the outstanding flag in bit 0, the kind in bits 2:1 (0 load/store, 1 fetch, 2 DMA), the direction in bit 3 (1 = write) and the master ID in bits 7:4, with 8 meaning the hardware walker. The record is stored as presented.
- R6: While the outstanding flag is set, later events still set their status bits, but words 2 and 3 keep the first fault's values.
- R7: Writing 1 to bit 0 of word 3 clears the outstanding flag. The next event then captures a new record.
- R8: An event in the same cycle as a write-1 clear of its status bit, or of the outstanding flag, wins: the bit stays set.
- R9: Every debug-time miss (event bit 2) loads its virtual address into word 4, even while a record is frozen.
- R10: Word 1 is a read/write enable mask. Words 5 to 7 read as zero. Read data reflects the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vec | input | NEVT | One-cycle event pulses, one per fault source |
| evt_vaddr | input | AW | Virtual address of the request that raised the event |
| evt_master | input | IDW | Master ID of that request |
| evt_kind | input | 2 | Request kind: 0 load/store, 1 fetch, 2 DMA |
| evt_write | input | 1 | 1 for a write request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest cases to reach from the ports are the races between an event and a software clear in the same cycle. These must hit both the status word and the outstanding flag. The bench lines an event pulse and a register write onto the same falling-edge drive. It then reads back both the status bit and the frozen record, which shows that the flag survived and that no recapture happened. A sweep covers every source under all 32 enable masks and checks status, interrupt, record fields and clearing for each combination.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RG_STATUS = 3'd0,
    RG_ENABLE = 3'd1,
    RG_FVA    = 3'd2,
    RG_FINFO  = 3'd3,
    RG_DBGVA  = 3'd4
  } reg_sel_e;

  // Event bit positions
  localparam int EV_MULTIHIT = 0;
  localparam int EV_WALKERR  = 1;
  localparam int EV_DBGMISS  = 2;
  localparam int EV_BADDESC  = 3;
  localparam int EV_MISS     = 4;
endpackage

// File: rtl/xf_status_bank.sv
module xf_status_bank #(
  parameter int NEVT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic            wr_sts,
  input  logic            wr_en,
  input  logic [NEVT-1:0] wdata,
  output logic [NEVT-1:0] status,
  output logic [NEVT-1:0] enable,
  output logic            irq
);
  logic [NEVT-1:0] sts_q;
  logic [NEVT-1:0] en_q;
  logic            irq_q;

  // One sticky flop per source; the event term is ORed last so it wins a clear
  for (genvar g = 0; g < NEVT; g++) begin : g_bit
    logic clr;
    assign clr = wr_sts & wdata[g];
    always_ff @(posedge clk) begin
      if (rst) sts_q[g] <= 1'b0;
      else     sts_q[g] <= (sts_q[g] & ~clr) | evt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wdata;
      irq_q <= |(sts_q & en_q);
    end
  end

  assign status = sts_q;
  assign enable = en_q;
  assign irq    = irq_q;
endmodule

// File: rtl/xf_capture.sv
module xf_capture #(
  parameter int NEVT    = 5,
  parameter int AW      = 32,
  parameter int IDW     = 4,
  parameter int DBG_IDX = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic [AW-1:0]   vaddr,
  input  logic [IDW-1:0]  master,
  input  logic [1:0]      kind,
  input  logic            wr_dir,
  input  logic            clr_ind,
  output logic            ind,
  output logic [AW-1:0]   cap_va,
  output logic [IDW-1:0]  cap_master,
  output logic [1:0]      cap_kind,
  output logic            cap_wr,
  output logic [AW-1:0]   dbg_va
);
  logic            ind_q;
  logic [AW-1:0]   va_q;
  logic [IDW-1:0]  mst_q;
  logic [1:0]      kind_q;
  logic            wr_q;
  logic [AW-1:0]   dbg_q;
  logic            any_evt;
  logic            take;

  assign any_evt = |evt;
  assign take    = any_evt & ~ind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_q  <= 1'b0;
      va_q   <= '0;
      mst_q  <= '0;
      kind_q <= '0;
      wr_q   <= 1'b0;
      dbg_q  <= '0;
    end else begin
      ind_q <= (ind_q & ~clr_ind) | any_evt;
      if (take) begin
        va_q   <= vaddr;
        mst_q  <= master;
        kind_q <= kind;
        wr_q   <= wr_dir;
      end
      if (evt[DBG_IDX]) dbg_q <= vaddr;
    end
  end

  assign ind        = ind_q;
  assign cap_va     = va_q;
  assign cap_master = mst_q;
  assign cap_kind   = kind_q;
  assign cap_wr     = wr_q;
  assign dbg_va     = dbg_q;
endmodule

// File: rtl/xf_regport.sv
module xf_regport
  import xf_pkg::*;
#(
  parameter int NEVT = 5,
  parameter int AW   = 32,
  parameter int IDW  = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NEVT-1:0]   status,
  input  logic [NEVT-1:0]   enable,
  input  logic              ind,
  input  logic [AW-1:0]     cap_va,
  input  logic [IDW-1:0]    cap_master,
  input  logic [1:0]        cap_kind,
  input  logic              cap_wr,
  input  logic [AW-1:0]     dbg_va,
  output logic              wr_sts,
  output logic              wr_en,
  output logic              clr_ind,
  output logic [NEVT-1:0]   wfield,
  output logic [DW-1:0]     rdata
);
  localparam int INFO_W = IDW + 4;

  logic [DW-1:0]     rd_d;
  logic [DW-1:0]     rd_q;
  logic [INFO_W-1:0] info;

  assign wr_sts  = we && (addr == RG_STATUS);
  assign wr_en   = we && (addr == RG_ENABLE);
  assign clr_ind = we && (addr == RG_FINFO) && wdata[0];
  assign wfield  = wdata[NEVT-1:0];

  assign info = {cap_master, cap_wr, cap_kind, ind};

  always_comb begin
    case (addr)
      RG_STATUS: rd_d = DW'(status);
      RG_ENABLE: rd_d = DW'(enable);
      RG_FVA:    rd_d = DW'(cap_va);
      RG_FINFO:  rd_d = DW'(info);
      RG_DBGVA:  rd_d = DW'(dbg_va);
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit
  import xf_pkg::*;
#(
  parameter int NEVT = 5,
  parameter int AW   = 32,
  parameter int IDW  = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEVT-1:0]   evt_vec,
  input  logic [AW-1:0]     evt_vaddr,
  input  logic [IDW-1:0]    evt_master,
  input  logic [1:0]        evt_kind,
  input  logic              evt_write,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic            wr_sts_w, wr_en_w, clr_ind_w;
  logic [NEVT-1:0] wfield_w;
  logic [NEVT-1:0] sts_w, en_w;
  logic            ind_w;
  logic [AW-1:0]   fva_w, dbgva_w;
  logic [IDW-1:0]  fmst_w;
  logic [1:0]      fkind_w;
  logic            fwr_w;

  xf_status_bank #(.NEVT(NEVT)) bank_i (
    .clk(clk), .rst(rst), .evt(evt_vec),
    .wr_sts(wr_sts_w), .wr_en(wr_en_w), .wdata(wfield_w),
    .status(sts_w), .enable(en_w), .irq(irq)
  );

  xf_capture #(.NEVT(NEVT), .AW(AW), .IDW(IDW), .DBG_IDX(EV_DBGMISS)) cap_i (
    .clk(clk), .rst(rst), .evt(evt_vec), .vaddr(evt_vaddr),
    .master(evt_master), .kind(evt_kind), .wr_dir(evt_write),
    .clr_ind(clr_ind_w), .ind(ind_w), .cap_va(fva_w),
    .cap_master(fmst_w), .cap_kind(fkind_w), .cap_wr(fwr_w),
    .dbg_va(dbgva_w)
  );

  xf_regport #(.NEVT(NEVT), .AW(AW), .IDW(IDW), .DW(DW)) port_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(sts_w), .enable(en_w), .ind(ind_w), .cap_va(fva_w),
    .cap_master(fmst_w), .cap_kind(fkind_w), .cap_wr(fwr_w),
    .dbg_va(dbgva_w), .wr_sts(wr_sts_w), .wr_en(wr_en_w),
    .clr_ind(clr_ind_w), .wfield(wfield_w), .rdata(reg_rdata)
  );
endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
  parameter int NEVT    = 5,
  parameter int AW      = 32,
  parameter int DBG_IDX = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NEVT-1:0] evt_vec,
  input logic [AW-1:0]   evt_vaddr,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [NEVT-1:0] wbits,
  input logic [NEVT-1:0] status,
  input logic [NEVT-1:0] enable,
  input logic            ind,
  input logic [AW-1:0]   cap_va,
  input logic [AW-1:0]   dbg_va,
  input logic            irq
);
  logic sts_write;
  assign sts_write = reg_we && (reg_addr == 3'd0);

  for (genvar g = 0; g < NEVT; g++) begin : g_chk
    // R2 and R8: an event always leaves its bit set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
      evt_vec[g] |=> status[g]);
    // R2: no bit rises without its event
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      (!status[g] && !evt_vec[g]) |=> !status[g]);
    // R3: write-1 clear without a competing event
    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
      (sts_write && wbits[g] && !evt_vec[g]) |=> !status[g]);
  end

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(status) & $past(enable))));

  p_first_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (!ind && (|evt_vec)) |=> (ind && cap_va == $past(evt_vaddr)));

  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    ind |=> $stable(cap_va));

  p_ind_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (|evt_vec) |=> ind);

  p_dbg_track_r9: assert property (@(posedge clk) disable iff (rst)
    evt_vec[DBG_IDX] |=> (dbg_va == $past(evt_vaddr)));
endmodule

bind xlat_fault_unit xf_checker #(.NEVT(NEVT), .AW(AW), .DBG_IDX(xf_pkg::EV_DBGMISS)) chk_i (
  .clk(clk), .rst(rst), .evt_vec(evt_vec), .evt_vaddr(evt_vaddr),
  .reg_we(reg_we), .reg_addr(reg_addr), .wbits(reg_wdata[NEVT-1:0]),
  .status(sts_w), .enable(en_w), .ind(ind_w), .cap_va(fva_w),
  .dbg_va(dbgva_w), .irq(irq)
);

// File: tb/xlat_fault_unit_tb_top.sv
module xlat_fault_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEVT = 5;
  localparam int AW   = 32;
  localparam int IDW  = 4;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NEVT-1:0] evt_vec = '0;
  logic [AW-1:0]   evt_vaddr = '0;
  logic [IDW-1:0]  evt_master = '0;
  logic [1:0]      evt_kind = '0;
  logic            evt_write = 1'b0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_fault_unit #(.NEVT(NEVT), .AW(AW), .IDW(IDW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .evt_vec(evt_vec), .evt_vaddr(evt_vaddr),
    .evt_master(evt_master), .evt_kind(evt_kind), .evt_write(evt_write),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic fire(input int idx, input logic [31:0] va, input logic [3:0] mst,
                      input logic [1:0] knd, input logic w);
    evt_vec = NEVT'(1) << idx;
    evt_vaddr = va; evt_master = mst; evt_kind = knd; evt_write = w;
    @(negedge clk);
    evt_vec = '0;
  endtask

  function automatic logic [31:0] info(input logic [3:0] mst, input logic w,
                                       input logic [1:0] knd, input logic f);
    return {24'h0, mst, w, knd, f};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] va;
    logic [3:0]  mst;
    logic [1:0]  knd;
    logic        w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end

    // Sweep: every source under every enable mask (R2 R4 R5 R7 R9 R10 R3)
    for (int i = 0; i < NEVT; i++) begin
      for (int m = 0; m < 32; m++) begin
        va  = 32'hA000_0000 | (32'(m) << 8) | 32'(i);
        mst = 4'((i * 3 + m) % 16);
        knd = 2'(m % 3);
        w   = m[0];
        wr(3'd1, 32'(m));
        fire(i, va, mst, knd, w);
        rd(3'd0, v);
        chk("R2 status", v, 32'(1) << i);
        chk("R4 irq", {31'b0, irq}, {31'b0, m[i]});
        rd(3'd3, v);
        chk("R5 info", v, info(mst, w, knd, 1'b1));
        rd(3'd2, v);
        chk("R5 va", v, va);
        rd(3'd1, v);
        chk("R10 enable", v, 32'(m));
        if (i == 2) begin
          rd(3'd4, v);
          chk("R9 dbg va", v, va);
        end
        wr(3'd0, 32'h1F);
        wr(3'd3, 32'h1);
        rd(3'd0, v);
        chk("R3 cleared", v, 0);
        chk("R4 irq low", {31'b0, irq}, 0);
        rd(3'd3, v);
        chk("R7 flag clear", {31'b0, v[0]}, 0);
      end
    end

    // R5: hardware walker master ID 8 and a DMA read
    wr(3'd1, 32'h0);
    fire(4, 32'h1234_5678, 4'd8, 2'd2, 1'b0);
    rd(3'd3, v);
    chk("R5 walker id", v, info(4'd8, 1'b0, 2'd2, 1'b1));
    // R6: a later fault does not overwrite the record
    fire(0, 32'hDEAD_0000, 4'd3, 2'd1, 1'b1);
    rd(3'd0, v);
    chk("R6 status both", v, 32'h11);
    rd(3'd2, v);
    chk("R6 va frozen", v, 32'h1234_5678);
    rd(3'd3, v);
    chk("R6 info frozen", v, info(4'd8, 1'b0, 2'd2, 1'b1));
    // R9: debug miss updates while frozen
    fire(2, 32'hBEEF_0004, 4'd1, 2'd0, 1'b0);
    rd(3'd4, v);
    chk("R9 dbg while frozen", v, 32'hBEEF_0004);
    rd(3'd2, v);
    chk("R6 va still frozen", v, 32'h1234_5678);
    // R3: writing zeros leaves bits
    wr(3'd0, 32'h0);
    rd(3'd0, v);
    chk("R3 write0 keeps", v, 32'h15);
    wr(3'd0, 32'h01);
    rd(3'd0, v);
    chk("R3 partial clear", v, 32'h14);
    // R10: unmapped words read zero while state is nonzero
    rd(3'd5, v);
    chk("R10 word5", v, 0);
    rd(3'd7, v);
    chk("R10 word7", v, 0);
    // R7: clear flag, next event recaptures
    wr(3'd3, 32'h1);
    fire(3, 32'h0000_C0DE, 4'd6, 2'd1, 1'b1);
    rd(3'd2, v);
    chk("R7 recapture va", v, 32'h0000_C0DE);
    rd(3'd3, v);
    chk("R7 recapture info", v, info(4'd6, 1'b1, 2'd1, 1'b1));
    // R8: event and status clear in the same cycle
    evt_vec = 5'b00010; evt_vaddr = 32'h7777_0000;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1F;
    @(negedge clk);
    evt_vec = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(3'd0, v);
    chk("R8 status wins", v, 32'h02);
    // R8: event and flag clear in the same cycle
    evt_vec = 5'b00001; evt_vaddr = 32'h5555_0000;
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1;
    @(negedge clk);
    evt_vec = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(3'd3, v);
    chk("R8 flag wins", v, info(4'd6, 1'b1, 2'd1, 1'b1));
    rd(3'd2, v);
    chk("R8 no recapture", v, 32'h0000_C0DE);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule